// File: doc/BRIEF.md
# Accumulator Execute Datapath with Direction-Routed Writeback

This block is the execute stage of a small accumulator machine. It holds a 32-bit accumulator and a file of eight 32-bit general registers. On every clock edge where the execute enable is high, it decodes one opcode byte and updates that state. The low nibble of the byte picks the operation. The high nibble carries either a 4-bit constant or a direction flag together with a register index.

The register-operand operations are: transfer, add, subtract, multiply, unsigned less-or-equal, OR and NAND. Each one uses the selected register as its left operand and the accumulator as its right operand. The direction flag then sends the result either to the accumulator or back into the selected register. The accumulator-only operations are: load a small signed constant, add a small signed constant, and increment by one. The control and output codes (0 to 3) and two reserved codes leave all state alone. Program counter, stack, fetch and character output belong to neighbouring blocks.

All state is registered. A result is visible on the outputs in the clock cycle after the enabled edge. The register file is exposed as one flat vector, with register k in bits [32k+31:32k].

Top module: `acc_alu_exec`

## Requirements
- R1: While `rst_n` is low, the accumulator and all eight registers are cleared to zero (asynchronous clear), and they read zero on the cycle after reset is released.
- R2: At a clock edge where `exec_en` is 0, neither the accumulator nor any register changes, whatever the opcode.
- R3: Code 7 (opcode[3:0]=7) is a transfer. With opcode[7]=1, register opcode[6:4] takes the accumulator value. With opcode[7]=0, the accumulator takes that register's value.
- R4: Codes 8 and 9 compute register plus accumulator and register minus accumulator, modulo 2^32.
- R5: Code 10 computes register times accumulator and keeps the low 32 bits of the product.
- R6: Code 13 gives 1, zero-extended to 32 bits, when the register is unsigned less than or equal to the accumulator. Otherwise it gives 0.
- R7: Code 14 gives the bitwise OR of register and accumulator. Code 15 gives the bitwise inverse of their AND.
- R8: For codes 8, 9, 10, 13, 14 and 15, opcode[7]=1 writes the result to register opcode[6:4] and leaves the accumulator unchanged. opcode[7]=0 writes the result to the accumulator and leaves every register unchanged.
- R9: Code 4 loads the accumulator with opcode[7:4] minus 8, sign-extended (range -8..7). No register changes.
- R10: Code 5 adds opcode[7:4] minus 8 to the accumulator. Code 6 adds 1 to the accumulator. Both wrap modulo 2^32, and no register changes.
- R11: Codes 0, 1, 2, 3, 11 and 12 change neither the accumulator nor any register.
- R12: An enabled operation's result appears on `acc_q`/`regs_q` in the cycle after the clock edge that executed it, and it is the state seen by the next operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute the opcode at this edge when high |
| opcode | input | 8 | Opcode byte: [3:0] operation, [7] direction, [6:4] register, [7:4] constant |
| acc_q | output | 32 | Current accumulator value |
| regs_q | output | 256 | Register file, register k in bits [32k+31:32k] |

## Verification
The bound checker checks, on every cycle, the properties that follow from one step of state: idle and reserved codes hold everything, each direction leaves the unchosen side untouched, and the accumulator-destination results of load, increment, add, subtract, multiply, compare and NAND are correct. It also checks the clear during reset. Register-destination results and chains of dependent operations can only be shown by the bench. It sweeps all 256 opcode bytes, runs a long fixed-seed random stream against a reference model, and adds directed cases: compare on equal operands, results that wrap, and a reset in the middle of the run.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   // Operation selected by opcode[3:0]; the numbering is part of the encoding.
   typedef enum logic [3:0] {
      OC_CTL0  = 4'd0,
      OC_CTL1  = 4'd1,
      OC_CTL2  = 4'd2,
      OC_CTL3  = 4'd3,
      OC_LDK   = 4'd4,
      OC_ADDK  = 4'd5,
      OC_BUMP  = 4'd6,
      OC_XFER  = 4'd7,
      OC_ADD   = 4'd8,
      OC_SUB   = 4'd9,
      OC_MUL   = 4'd10,
      OC_RSV0  = 4'd11,
      OC_RSV1  = 4'd12,
      OC_LEU   = 4'd13,
      OC_OR    = 4'd14,
      OC_NAND  = 4'd15
   } op_code_e;

   // Bit positions inside the opcode byte.
   localparam int unsigned OPC_W     = 8;
   localparam int unsigned CODE_LSB  = 0;
   localparam int unsigned ARG_LSB   = 4;
   localparam int unsigned ARG_W     = 4;
   localparam int unsigned DIR_BIT   = 7;
   localparam int unsigned MAX_SEL_W = 3;

   function automatic logic is_binop(op_code_e c);
      return (c == OC_ADD) || (c == OC_SUB) || (c == OC_MUL) ||
             (c == OC_LEU) || (c == OC_OR)  || (c == OC_NAND);
   endfunction

   function automatic logic is_acc_only(op_code_e c);
      return (c == OC_LDK) || (c == OC_ADDK) || (c == OC_BUMP);
   endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic [OPC_W-1:0] opcode,
   output op_code_e         code,
   output logic             dir,
   output logic [SEL_W-1:0] rsel,
   output logic [ARG_W-1:0] narg,
   output logic             to_acc,
   output logic             to_reg
);

   logic routed;

   assign code   = op_code_e'(opcode[CODE_LSB +: 4]);
   assign dir    = opcode[DIR_BIT];
   assign narg   = opcode[ARG_LSB +: ARG_W];
   assign rsel   = opcode[ARG_LSB +: SEL_W];

   // Transfer and binary operations follow the direction flag.
   assign routed = is_binop(code) || (code == OC_XFER);

   always_comb begin
      to_acc = 1'b0;
      to_reg = 1'b0;
      if (is_acc_only(code)) begin
         to_acc = 1'b1;
      end else if (routed) begin
         to_acc = ~dir;
         to_reg = dir;
      end
   end

endmodule

// File: rtl/acc_alu_func.sv
module acc_alu_func
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter bit          MUL_SHIFT_ADD = 1'b0
) (
   input  op_code_e          code,
   input  logic              dir,
   input  logic [ARG_W-1:0]  narg,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] result
);

   localparam logic [DATA_W-1:0] BIAS = DATA_W'(8);

   logic [DATA_W-1:0] karg;
   logic [DATA_W-1:0] prod;
   logic              leu;

   assign karg = {{(DATA_W-ARG_W){1'b0}}, narg} - BIAS;
   assign leu  = (lhs <= acc);

   generate
      if (MUL_SHIFT_ADD) begin : g_mul_shift
         always_comb begin
            prod = '0;
            for (int b = 0; b < int'(DATA_W); b++) begin
               if (acc[b]) prod = prod + (lhs << b);
            end
         end
      end else begin : g_mul_direct
         assign prod = lhs * acc;
      end
   endgenerate

   always_comb begin
      unique case (code)
         OC_LDK:  result = karg;
         OC_ADDK: result = acc + karg;
         OC_BUMP: result = acc + DATA_W'(1);
         OC_XFER: result = dir ? acc : lhs;
         OC_ADD:  result = lhs + acc;
         OC_SUB:  result = lhs - acc;
         OC_MUL:  result = prod;
         OC_LEU:  result = {{(DATA_W-1){1'b0}}, leu};
         OC_OR:   result = lhs | acc;
         OC_NAND: result = ~(lhs & acc);
         default: result = acc;
      endcase
   end

endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REG_COUNT = 8,
   parameter int unsigned SEL_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc_we,
   input  logic                        reg_we,
   input  logic [SEL_W-1:0]            idx,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           acc_q,
   output logic [DATA_W-1:0]           sel_q,
   output logic [REG_COUNT*DATA_W-1:0] regs_flat
);

   logic [DATA_W-1:0] acc_r;
   logic [DATA_W-1:0] regs [REG_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_r <= '0;
      else if (acc_we) acc_r <= wdata;
   end

   generate
      for (genvar g = 0; g < int'(REG_COUNT); g++) begin : g_reg
         logic hit;
         assign hit = reg_we && (idx == SEL_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs[g] <= '0;
            else if (hit) regs[g] <= wdata;
         end
         assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
      end
   endgenerate

   assign acc_q = acc_r;
   assign sel_q = regs[idx];

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned REG_COUNT     = 8,
   parameter bit          MUL_SHIFT_ADD = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        exec_en,
   input  logic [OPC_W-1:0]            opcode,
   output logic [DATA_W-1:0]           acc_q,
   output logic [REG_COUNT*DATA_W-1:0] regs_q
);

   localparam int unsigned SEL_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

   initial begin
      assert (DATA_W >= 8)
         else $fatal(1, "acc_alu_exec: DATA_W must be at least 8");
      assert (SEL_W <= MAX_SEL_W)
         else $fatal(1, "acc_alu_exec: register index exceeds opcode field");
      assert (REG_COUNT == (1 << SEL_W))
         else $fatal(1, "acc_alu_exec: REG_COUNT must be a power of two");
   end

   op_code_e          code;
   logic              dir;
   logic [SEL_W-1:0]  rsel;
   logic [ARG_W-1:0]  narg;
   logic              to_acc;
   logic              to_reg;
   logic [DATA_W-1:0] sel_val;
   logic [DATA_W-1:0] result;

   acc_alu_decode #(.SEL_W(SEL_W)) u_dec (
      .opcode (opcode),
      .code   (code),
      .dir    (dir),
      .rsel   (rsel),
      .narg   (narg),
      .to_acc (to_acc),
      .to_reg (to_reg)
   );

   acc_alu_func #(.DATA_W(DATA_W), .MUL_SHIFT_ADD(MUL_SHIFT_ADD)) u_func (
      .code   (code),
      .dir    (dir),
      .narg   (narg),
      .lhs    (sel_val),
      .acc    (acc_q),
      .result (result)
   );

   acc_alu_state #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .SEL_W(SEL_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_we    (exec_en && to_acc),
      .reg_we    (exec_en && to_reg),
      .idx       (rsel),
      .wdata     (result),
      .acc_q     (acc_q),
      .sel_q     (sel_val),
      .regs_flat (regs_q)
   );

endmodule

// File: rtl/acc_alu_exec_chk.sv
module acc_alu_exec_chk
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REG_COUNT = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        exec_en,
   input logic [OPC_W-1:0]            opcode,
   input logic [DATA_W-1:0]           acc_q,
   input logic [REG_COUNT*DATA_W-1:0] regs_q
);

   localparam int unsigned SEL_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

   logic [3:0]        c;
   logic              d;
   logic [SEL_W-1:0]  ix;
   logic [DATA_W-1:0] rv;
   logic [DATA_W-1:0] kv;
   logic              bin;

   assign c   = opcode[3:0];
   assign d   = opcode[7];
   assign ix  = opcode[4 +: SEL_W];
   assign rv  = regs_q[int'(ix)*DATA_W +: DATA_W];
   assign kv  = DATA_W'(opcode[7:4]) - DATA_W'(8);
   assign bin = (c == 4'd8) || (c == 4'd9) || (c == 4'd10) ||
                (c == 4'd13) || (c == 4'd14) || (c == 4'd15);

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (acc_q == '0) && (regs_q == '0));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(acc_q) && $stable(regs_q));

   p_xfer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd7) && !d |=> acc_q == $past(rv));

   p_add_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd8) && !d |=> acc_q == $past(rv) + $past(acc_q));

   p_sub_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd9) && !d |=> acc_q == $past(rv) - $past(acc_q));

   p_mul_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd10) && !d |=> acc_q == DATA_W'($past(rv) * $past(acc_q)));

   p_leu_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd13) && !d |=>
         acc_q == {{(DATA_W-1){1'b0}}, ($past(rv) <= $past(acc_q))});

   p_nand_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd15) && !d |=> acc_q == ~($past(rv) & $past(acc_q)));

   p_dir_reg_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && bin && d |=> $stable(acc_q));

   p_dir_acc_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && bin && !d |=> $stable(regs_q));

   p_ldk_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd4) |=> (acc_q == $past(kv)) && $stable(regs_q));

   p_bump_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd6) |=> (acc_q == $past(acc_q) + DATA_W'(1)) && $stable(regs_q));

   p_addk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && (c == 4'd5) |=> (acc_q == $past(acc_q) + $past(kv)) && $stable(regs_q));

   p_inert_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && ((c <= 4'd3) || (c == 4'd11) || (c == 4'd12)) |=>
         $stable(acc_q) && $stable(regs_q));

endmodule

bind acc_alu_exec acc_alu_exec_chk #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_chk (.*);

// File: tb/acc_alu_exec_tb.sv
`timescale 1ns/1ps
module acc_alu_exec_tb;

   localparam int W = 32;
   localparam int NR = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            exec_en = 1'b0;
   logic [7:0]      opcode = 8'h00;
   logic [W-1:0]    acc_q;
   logic [NR*W-1:0] regs_q;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [W-1:0] m_acc;
   logic [W-1:0] m_reg [NR];

   always #2.5 clk = ~clk;

   acc_alu_exec u_dut (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en),
      .opcode(opcode), .acc_q(acc_q), .regs_q(regs_q)
   );

   function automatic string req_of(logic [7:0] op, bit en);
      if (!en) return "R2";
      case (op[3:0])
         4'd4:         return "R9";
         4'd5, 4'd6:   return "R10";
         4'd7:         return "R3,R12";
         4'd8, 4'd9:   return "R4,R8";
         4'd10:        return "R5,R8";
         4'd13:        return "R6,R8";
         4'd14, 4'd15: return "R7,R8";
         default:      return "R11";
      endcase
   endfunction

   task automatic model_reset();
      m_acc = '0;
      for (int i = 0; i < NR; i++) m_reg[i] = '0;
   endtask

   task automatic model_step(logic [7:0] op);
      logic [W-1:0] g, t, k;
      bit d;
      int r;
      d = op[7];
      r = int'(op[6:4]);
      g = m_reg[r];
      k = W'(op[7:4]) - 32'd8;
      t = '0;
      case (op[3:0])
         4'd4: m_acc = k;
         4'd5: m_acc = m_acc + k;
         4'd6: m_acc = m_acc + 32'd1;
         4'd7: if (d) m_reg[r] = m_acc; else m_acc = g;
         4'd8, 4'd9, 4'd10, 4'd13, 4'd14, 4'd15: begin
            case (op[3:0])
               4'd8:    t = g + m_acc;
               4'd9:    t = g - m_acc;
               4'd10:   t = W'(64'(g) * 64'(m_acc));
               4'd13:   t = (g <= m_acc) ? 32'd1 : 32'd0;
               4'd14:   t = g | m_acc;
               default: t = ~(g & m_acc);
            endcase
            if (d) m_reg[r] = t; else m_acc = t;
         end
         default: ;
      endcase
   endtask

   task automatic check_state(string tag);
      bit bad;
      bad = 1'b0;
      n_vec++;
      if (acc_q !== m_acc) begin
         $display("FAIL %s acc: actual %h expected %h", tag, acc_q, m_acc);
         bad = 1'b1;
      end
      for (int i = 0; i < NR; i++) begin
         if (regs_q[i*W +: W] !== m_reg[i]) begin
            $display("FAIL %s reg%0d: actual %h expected %h", tag, i, regs_q[i*W +: W], m_reg[i]);
            bad = 1'b1;
         end
      end
      if (bad) n_bad++;
   endtask

   // Caller is at a falling edge; the result is sampled at the next one.
   task automatic apply(logic [7:0] op, bit en);
      opcode  = op;
      exec_en = en;
      if (en) model_step(op);
      @(negedge clk);
      check_state($sformatf("%s op=%h en=%0d", req_of(op, en), op, en));
   endtask

   task automatic do_reset(string tag);
      rst_n = 1'b0;
      exec_en = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state(tag);
   endtask

   initial begin
      logic [7:0] op;
      void'($urandom(32'h1D5EED));
      model_reset();
      @(negedge clk);
      do_reset("R1 initial");

      // R6 on equal operands, then a large accumulator; results into a register.
      apply(8'hD4, 1'b1);   // acc = 5
      apply(8'hA7, 1'b1);   // reg2 = acc
      apply(8'h2D, 1'b1);   // acc = (reg2 <= acc) = 1
      apply(8'h04, 1'b1);   // acc = -8
      apply(8'hAD, 1'b1);   // reg2 = (5 <= FFFFFFF8) = 1
      apply(8'h1D, 1'b1);   // acc = (reg1=0 <= acc) = 1

      // R4/R10 wrap: acc = -1, reg1 = -1, acc += 7, acc = reg1 + acc.
      apply(8'h74, 1'b1);
      apply(8'h97, 1'b1);
      apply(8'hF5, 1'b1);
      apply(8'h18, 1'b1);
      apply(8'h06, 1'b1);   // R10 bump
      apply(8'h19, 1'b1);   // R4 reg1 - acc
      apply(8'h9A, 1'b1);   // R5 reg1 = reg1 * acc

      // Sweep every opcode byte.
      for (int i = 0; i < 256; i++) apply(8'(i), 1'b1);

      // R2: disabled edges must leave state untouched.
      for (int i = 0; i < 16; i++) apply(8'($urandom), 1'b0);

      // Random stream, mostly enabled, biased toward state-spreading ops.
      for (int i = 0; i < 3000; i++) begin
         op = 8'($urandom);
         if (($urandom % 8) == 0) op[3:0] = 4'd10;
         apply(op, ($urandom % 10) != 0);
      end

      // R1: reset in the middle of a run.
      do_reset("R1 mid-run");
      apply(8'h54, 1'b1);   // R9 acc = -3
      apply(8'hF7, 1'b1);   // R3 reg7 = acc

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule